// File: doc/BRIEF.md
# Serial Flash Byte-Lane SPI Controller

This block is a single-lane SPI master for talking to serial flash devices in plain one-bit mode. A host writes and reads a small set of word-wide registers. Transmit data goes into a 16-entry TX FIFO through one of four ports. One port queues a full 4-byte word. The other three queue 1, 2 or 3 bytes. A shifter takes one entry at a time and drives exactly eight clock pulses per queued byte. It works in SPI mode 0, most significant bit first, and it captures the same number of bytes from the device into one 32-bit word of a 16-entry RX FIFO.

Chip select is a plain register bit that the host controls. The host can therefore hold a device selected across several entries, for example an ID-read opcode byte followed by two full words that clock the reply out. The controller enforces a simple access-order rule on the transmit ports. A write that breaks the rule is discarded and raises a sticky error flag. Status bits report whether the RX FIFO is non-empty or full, whether the TX FIFO is full, a programmable TX-occupancy threshold, and a sticky RX-underflow flag.

Register offsets (addr_i): 0 control, 1 status, 2 full-word TX port, 3 one-byte TX port, 4 two-byte TX port, 5 three-byte TX port, 6 RX data, 7 TX threshold.

Top module: `spi_io_ctrl`

## Requirements
- R1: A write to offset 2 queues four bytes that produce exactly 32 rising SCK edges. Byte k is wdata[8k+7:8k], sent in the order k=0,1,2,3, each byte MSB first. SCK idles low, and MOSI is stable at each rising edge (mode 0).
- R2: Writes to offsets 3, 4 and 5 queue the lowest 1, 2 or 3 bytes of wdata and produce exactly 8, 16 or 24 rising SCK edges. Higher bytes of wdata are not sent.
- R3: Each sent entry pushes exactly one word into the RX FIFO. The byte captured k-th (k from 0) lands in bits [8k+7:8k], and bytes not clocked read as zero.
- R4: A write to offsets 3–5 while the TX FIFO holds any entry is dropped. So is a write to offset 2 while the TX FIFO holds any entry and the last accepted TX write was partial. Such a write sends nothing and sets status bit 4. Writing 1 to status bit 4 clears it.
- R5: cs_n_o is the inverse of control bit 0 and does not change during transfers.
- R6: Status bit 3 is 1 exactly when the queued TX entries plus the entry being shifted are at most the threshold register (offset 7). With threshold 0, the bit means the TX FIFO is empty and the shifter is idle.
- R7: Status bit 0 (RX not empty) rises only after the last bit of an entry has been clocked, never during the transfer.
- R8: A read of offset 6 returns and removes the oldest RX word. A read while the RX FIFO is empty returns 0 and sets status bit 5, which a write of 1 to that bit clears.
- R9: Each SCK half period lasts N+1 clock cycles, where N is control bits [3:1].
- R10: Consecutive writes to offset 2 after a full-word write are accepted while earlier entries are still queued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (pops RX at offset 6) |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| sck_o | output | 1 | SPI serial clock |
| mosi_o | output | 1 | SPI data to device |
| miso_i | input | 1 | SPI data from device |
| cs_n_o | output | 1 | Active-low chip select |

## Verification
Two things can happen in the same cycle: the shifter popping the TX FIFO to start an entry, and the host pushing a new word. Back-to-back host writes land exactly on the pop edge, both for the legal full-word sequence and for an illegal partial write that follows. The result is judged at the bus. The total count of rising SCK edges must equal eight times the bytes of the accepted writes only, and the RX FIFO must then yield one correctly packed word per accepted entry. A read of an empty RX FIFO must return zero.

// File: rtl/spi_io_pkg.sv
package spi_io_pkg;

    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_STAT = 3'd1,
        REG_TXW  = 3'd2,
        REG_TX1  = 3'd3,
        REG_TX2  = 3'd4,
        REG_TX3  = 3'd5,
        REG_RXD  = 3'd6,
        REG_THR  = 3'd7
    } reg_addr_e;

    // status bit positions
    localparam int ST_RX_NE  = 0;
    localparam int ST_RX_FUL = 1;
    localparam int ST_TX_FUL = 2;
    localparam int ST_THR    = 3;
    localparam int ST_ORDER  = 4;
    localparam int ST_UDF    = 5;

    // one queued transmit entry: last byte index plus data
    typedef struct packed {
        logic [1:0]  last;
        logic [31:0] data;
    } tx_entry_t;

endpackage

// File: rtl/spi_io_fifo.sv
module spi_io_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push_i,
    input  logic [WIDTH-1:0]               data_i,
    input  logic                           pop_i,
    output logic [WIDTH-1:0]               data_o,
    output logic [$clog2(DEPTH+1)-1:0]     count_o,
    output logic                           full_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wp;
        logic [AW-1:0]               rp;
        logic [CW-1:0]               cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push_i && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop_i && (st_q.cnt != '0);
        if (do_push) begin
            st_d.mem[st_q.wp] = data_i;
            st_d.wp = (st_q.wp == AW'(DEPTH-1)) ? '0 : st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == AW'(DEPTH-1)) ? '0 : st_q.rp + 1'b1;
        end
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o  = st_q.mem[st_q.rp];
    assign count_o = st_q.cnt;
    assign full_o  = (st_q.cnt == CW'(DEPTH));

    // R3: an accepted push without pop grows occupancy by one
    a_r3_push_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !full_o && !pop_i) |=> (count_o == $past(count_o) + 1'b1));

endmodule

// File: rtl/spi_io_shift.sv
module spi_io_shift #(
    parameter int DIVW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [31:0]     data_i,
    input  logic [1:0]      last_i,
    input  logic [DIVW-1:0] div_i,
    input  logic            miso_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [31:0]     rx_o,
    output logic            sck_o,
    output logic            mosi_o
);
    typedef struct packed {
        logic            busy;
        logic            sck;
        logic [DIVW-1:0] cnt;
        logic [4:0]      bidx;
        logic [1:0]      last;
        logic [31:0]     tx;
        logic [31:0]     rx;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic [4:0] pos;
    logic       done;

    // byte lane from upper index bits, MSB-first bit within the byte
    assign pos = {st_q.bidx[4:3], ~st_q.bidx[2:0]};

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.sck  = 1'b0;
                st_d.cnt  = '0;
                st_d.bidx = '0;
                st_d.last = last_i;
                st_d.tx   = data_i;
                st_d.rx   = '0;
            end
        end else if (st_q.cnt == div_i) begin
            st_d.cnt = '0;
            st_d.sck = ~st_q.sck;
            if (!st_q.sck) begin
                st_d.rx[pos] = miso_i;
            end else if (st_q.bidx == {st_q.last, 3'b111}) begin
                st_d.busy = 1'b0;
                done      = 1'b1;
            end else begin
                st_d.bidx = st_q.bidx + 1'b1;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign done_o = done;
    assign rx_o   = st_q.rx;
    assign sck_o  = st_q.sck;
    assign mosi_o = st_q.busy ? st_q.tx[pos] : 1'b0;

    // R1: clock idles low whenever no entry is being shifted
    a_r1_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sck_o);
    // R2: bit index never passes the last bit of the entry's byte count
    a_r2_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (st_q.bidx <= {st_q.last, 3'b111}));
    // R7: completion ends the transfer on the following cycle
    a_r7_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!busy_o && !sck_o));

endmodule

// File: rtl/spi_io_ctrl.sv
module spi_io_ctrl #(
    parameter int FIFO_DEPTH = 16,
    parameter int DIVW       = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en_i,
    input  logic        rd_en_i,
    input  logic [2:0]  addr_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rdata_o,
    output logic        sck_o,
    output logic        mosi_o,
    input  logic        miso_i,
    output logic        cs_n_o
);
    import spi_io_pkg::*;

    localparam int CW = $clog2(FIFO_DEPTH+1);
    localparam int EW = $bits(tx_entry_t);

    typedef struct packed {
        logic            cs;
        logic [DIVW-1:0] div;
        logic [CW-1:0]   thr;
        logic            ord_err;
        logic            udf;
        logic            last_part;
    } ctl_st_t;

    ctl_st_t   st_d, st_q;
    tx_entry_t tx_in, tx_head;
    logic [EW-1:0] tx_head_raw;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic          tx_full, rx_full;
    logic          is_tx, is_part, violation, tx_push, tx_pop;
    logic          rx_pop, rx_empty_rd, thr_flag;
    logic          busy, done;
    logic [31:0]   rx_word, rx_head, status;

    always_comb begin
        st_d        = st_q;
        is_tx       = wr_en_i && (addr_i >= REG_TXW) && (addr_i <= REG_TX3);
        is_part     = (addr_i != REG_TXW);
        violation   = is_tx && (tx_cnt != '0) && (is_part || st_q.last_part);
        tx_push     = is_tx && !violation;
        tx_in.data  = wdata_i;
        tx_in.last  = is_part ? 2'(addr_i - 3'd3) : 2'd3;
        rx_pop      = rd_en_i && (addr_i == REG_RXD) && (rx_cnt != '0);
        rx_empty_rd = rd_en_i && (addr_i == REG_RXD) && (rx_cnt == '0);
        tx_pop      = !busy && (tx_cnt != '0);

        if (tx_push && !tx_full) st_d.last_part = is_part;
        if (wr_en_i && addr_i == REG_CTRL) begin
            st_d.cs  = wdata_i[0];
            st_d.div = wdata_i[DIVW:1];
        end
        if (wr_en_i && addr_i == REG_THR) st_d.thr = wdata_i[CW-1:0];
        if (wr_en_i && addr_i == REG_STAT) begin
            if (wdata_i[ST_ORDER]) st_d.ord_err = 1'b0;
            if (wdata_i[ST_UDF])   st_d.udf     = 1'b0;
        end
        if (violation)   st_d.ord_err = 1'b1;
        if (rx_empty_rd) st_d.udf     = 1'b1;

        thr_flag = ((CW+1)'(tx_cnt) + (CW+1)'(busy)) <= (CW+1)'(st_q.thr);
        status   = '0;
        status[ST_RX_NE]  = (rx_cnt != '0);
        status[ST_RX_FUL] = rx_full;
        status[ST_TX_FUL] = tx_full;
        status[ST_THR]    = thr_flag;
        status[ST_ORDER]  = st_q.ord_err;
        status[ST_UDF]    = st_q.udf;

        case (addr_i)
            REG_CTRL: rdata_o = 32'({st_q.div, st_q.cs});
            REG_STAT: rdata_o = status;
            REG_THR:  rdata_o = 32'(st_q.thr);
            REG_RXD:  rdata_o = (rx_cnt != '0) ? rx_head : 32'd0;
            default:  rdata_o = 32'd0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_head = tx_entry_t'(tx_head_raw);
    assign cs_n_o  = ~st_q.cs;

    spi_io_fifo #(.WIDTH(EW), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(tx_push), .data_i(tx_in), .pop_i(tx_pop),
        .data_o(tx_head_raw), .count_o(tx_cnt), .full_o(tx_full)
    );

    spi_io_shift #(.DIVW(DIVW)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .start_i(tx_pop), .data_i(tx_head.data), .last_i(tx_head.last),
        .div_i(st_q.div), .miso_i(miso_i),
        .busy_o(busy), .done_o(done), .rx_o(rx_word),
        .sck_o(sck_o), .mosi_o(mosi_o)
    );

    spi_io_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(done), .data_i(rx_word), .pop_i(rx_pop),
        .data_o(rx_head), .count_o(rx_cnt), .full_o(rx_full)
    );

    // R4: a rule-breaking write raises the sticky order flag
    a_r4_order_flag: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> rdata_o[ST_ORDER] || addr_i != REG_STAT || st_q.ord_err);
    // R4: a rule-breaking write adds nothing to the TX FIFO
    a_r4_order_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (violation && !tx_pop) |=> $stable(tx_cnt));
    // R5: chip select follows the control write
    a_r5_cs_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == REG_CTRL) |=> (cs_n_o == !$past(wdata_i[0])));
    // R8: an empty RX read leaves the underflow flag set
    a_r8_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty_rd |=> st_q.udf);
    // R3: a finished entry always lands in the RX FIFO unless it is full
    a_r3_rx_push: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rx_full && !rx_pop) |=> (rx_cnt == $past(rx_cnt) + 1'b1));

endmodule

// File: tb/spi_io_ctrl_bench.sv
module spi_io_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sck, mosi, miso, cs_n;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int pulses = 0, negcnt = 0;
    int t_first = 0, t_second = 0;
    logic [31:0] mosi_log = '0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_io_ctrl u_spi_io_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n)
    );

    // device model: reply byte stream restarts when chip select is released
    function automatic logic [7:0] reply(input int k);
        case (k)
            0: reply = 8'h3C;
            1: reply = 8'h01;
            2: reply = 8'h02;
            3: reply = 8'h20;
            4: reply = 8'h4D;
            5: reply = 8'h00;
            6: reply = 8'h80;
            7: reply = 8'h43;
            8: reply = 8'h31;
            default: reply = 8'(k * 13 + 7);
        endcase
    endfunction

    assign miso = reply(negcnt / 8)[7 - (negcnt % 8)];

    always @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            pulses = 0;
            mosi_log = '0;
        end else begin
            if (pulses == 0) t_first = cyc;
            if (pulses == 1) t_second = cyc;
            pulses = pulses + 1;
            mosi_log = {mosi_log[30:0], mosi};
        end
    end

    always @(negedge sck or posedge cs_n) begin
        if (cs_n) negcnt = 0;
        else      negcnt = negcnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // tasks are entered at a falling clock edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd1, s);
            if (s[3]) break;
        end
    endtask

    localparam logic [37:0] VEC [8] = '{
        {3'd2, 3'd0, 32'h12345678},
        {3'd3, 3'd1, 32'h000000A5},
        {3'd4, 3'd2, 32'h0000C33C},
        {3'd5, 3'd3, 32'h00F00F5A},
        {3'd2, 3'd7, 32'hDEADBEEF},
        {3'd3, 3'd0, 32'hFFFFFF81},
        {3'd5, 3'd5, 32'h11223344},
        {3'd4, 3'd6, 32'hAB0000FF}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        logic [31:0] s, d, exp;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(3'd1, s);
        chk("R6 reset threshold flag", 32'(s[3]), 32'd1);
        chk("R7 reset rx empty", 32'(s[0]), 32'd0);
        chk("R5 reset cs_n", 32'(cs_n), 32'd1);
        chk("R1 reset sck low", 32'(sck), 32'd0);

        // vector table: port, divider, data
        foreach (VEC[i]) begin
            int len;
            logic [2:0] a;
            logic [2:0] n;
            a = VEC[i][37:35];
            n = VEC[i][34:32];
            len = (a == 3'd2) ? 4 : int'(a) - 2;
            wr(3'd0, {28'd0, n, 1'b1});
            wr(a, VEC[i][31:0]);
            wait_idle();
            chk($sformatf("R1 R2 pulses vec%0d", i), 32'(pulses), 32'(8 * len));
            exp = '0;
            for (int k = 0; k < len; k++) exp = (exp << 8) | 32'(VEC[i][8*k +: 8]);
            chk($sformatf("R1 mosi order vec%0d", i), mosi_log, exp);
            chk($sformatf("R9 half period vec%0d", i), 32'(t_second - t_first), 32'(2 * (int'(n) + 1)));
            chk($sformatf("R5 cs held vec%0d", i), 32'(cs_n), 32'd0);
            exp = '0;
            for (int k = 0; k < len; k++) exp[8*k +: 8] = reply(k);
            rd(3'd6, d);
            chk($sformatf("R3 rx word vec%0d", i), d, exp);
            wr(3'd0, {28'd0, n, 1'b0});
        end

        // ID read: opcode byte, then two full words under one chip select
        wr(3'd0, 32'h1);
        wr(3'd3, 32'h9F);
        wait_idle();
        wr(3'd2, 32'hFFFFFFFF);
        wr(3'd2, 32'hFFFFFFFF);
        wait_idle();
        chk("R10 id read pulses", 32'(pulses), 32'd72);
        rd(3'd6, d); chk("R3 id opcode word", d, 32'h0000003C);
        rd(3'd6, d); chk("R10 id word 1", d, 32'h4D200201);
        rd(3'd6, d); chk("R10 id word 2", d, 32'h31438000);
        rd(3'd1, s); chk("R4 no order error on legal sequence", 32'(s[4]), 32'd0);
        wr(3'd0, 32'h0);

        // partial write while a full word is still queued
        wr(3'd0, 32'hF);
        wr(3'd2, 32'h11111111);
        wr(3'd2, 32'h22222222);
        wr(3'd4, 32'h00003333);
        rd(3'd1, s); chk("R4 order error set", 32'(s[4]), 32'd1);
        wait_idle();
        chk("R4 dropped write sends nothing", 32'(pulses), 32'd64);
        rd(3'd6, d); rd(3'd6, d);
        rd(3'd6, d); chk("R8 empty read value", d, 32'd0);
        rd(3'd1, s);
        chk("R8 underflow flag", 32'(s[5]), 32'd1);
        chk("R8 rx empty after drain", 32'(s[0]), 32'd0);
        wr(3'd1, 32'h30);
        rd(3'd1, s); chk("R4 R8 flags cleared", 32'(s[5:4]), 32'd0);
        wr(3'd0, 32'h0);

        // full word right after a partial one that is still queued
        wr(3'd0, 32'h1);
        wr(3'd3, 32'h000000AA);
        wr(3'd2, 32'h55555555);
        rd(3'd1, s); chk("R4 full after partial flagged", 32'(s[4]), 32'd1);
        wait_idle();
        chk("R4 only partial byte clocked", 32'(pulses), 32'd8);
        rd(3'd6, d);
        rd(3'd1, s); chk("R3 one rx word per entry", 32'(s[0]), 32'd0);
        wr(3'd1, 32'h10);
        wr(3'd0, 32'h0);

        // threshold flag with three queued words
        wr(3'd7, 32'd2);
        wr(3'd0, 32'hF);
        wr(3'd2, 32'hA0A0A0A0);
        wr(3'd2, 32'hB0B0B0B0);
        wr(3'd2, 32'hC0C0C0C0);
        rd(3'd1, s); chk("R6 occupancy 3 above threshold 2", 32'(s[3]), 32'd0);
        wr(3'd7, 32'd3);
        rd(3'd1, s); chk("R6 occupancy 3 at threshold 3", 32'(s[3]), 32'd1);
        wr(3'd7, 32'd0);
        rd(3'd1, s); chk("R6 threshold 0 while busy", 32'(s[3]), 32'd0);
        wait_idle();
        chk("R10 three words clocked", 32'(pulses), 32'd96);
        rd(3'd6, d); rd(3'd6, d); rd(3'd6, d);
        wr(3'd0, 32'h0);

        // RX-not-empty must not rise before the last bit
        begin
            bit early = 1'b0;
            bit seen  = 1'b0;
            wr(3'd0, 32'h1);
            wr(3'd2, 32'h0F0F0F0F);
            for (int i = 0; i < 120; i++) begin
                rd(3'd1, s);
                if (s[0] && pulses != 32) early = 1'b1;
                if (s[0]) seen = 1'b1;
            end
            chk("R7 no early rx flag", 32'(early), 32'd0);
            chk("R7 rx flag after word", 32'(seen), 32'd1);
            chk("R5 cs low during transfer", 32'(cs_n), 32'd0);
            rd(3'd6, d);
            wr(3'd0, 32'h0);
            chk("R5 cs released", 32'(cs_n), 32'd1);
        end

        finish_run();
    end
endmodule